// File: doc/BRIEF.md
# Hyperbolic CORDIC Natural Logarithm Core

This core takes a normalized fixed-point mantissa `m` in the range [1,2) and returns ln(m) as an unsigned fixed-point fraction. It is the mantissa-logarithm kernel of a wide floating-point logarithm unit. Decoding of the format, special values, exponent scaling by ln 2 and the final merge and rounding all happen outside this core.

The computation uses the identity ln(m) = 2·atanh((m-1)/(m+1)). It is evaluated by hyperbolic CORDIC vectoring, with the state initialised to x = m+1, y = 1-m and z = 0. The residual y starts non-positive and stays non-positive throughout. Each micro-rotation either applies or skips, so the direction digit is 0 or 1. The iteration shifts run 1, 2, 3, ... and repeat the shifts 4, 13, 40, ... once each, so that one-sided steps still converge. Every clock cycle retires four micro-rotations. All sixteen apply/skip paths through the four rotations are built in parallel as a tree. The signs of the y values in that tree pick the four digits, and the chosen leaf becomes the next state. The angle constants atanh(2^-s) are computed while the design elaborates, at the working precision.

A one-cycle `start_i` loads the mantissa. After a fixed number of cycles, `done_o` pulses for one cycle with the result on `ln_o`. The result is held there until the next completion. The parameter `FRAC` sets the precision. The default of 112 fraction bits gives a 113-bit significand and 30 iteration cycles. The mantissa's integer bit must be 1.

Top module: `hyp_ln_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, `done_o` and `ln_o` are cleared to zero.
- R2: `start_i` is accepted when the core is idle. `done_o` is then high for exactly one cycle, NSTEP rising edges after the accepting edge. NSTEP = ceil((FRAC+2+k)/4), where k counts the repeated shifts 4, 13, 40, ... not above FRAC+2. This gives 9 for FRAC=32.
- R3: `mant_i` is unsigned Q1.FRAC with bit FRAC equal to 1. `ln_o` is unsigned Q0.FRAC. In the cycle `done_o` is high, `ln_o` is within 3 LSB of ln(mant_i·2^-FRAC)·2^FRAC.
- R4: For `mant_i` = exactly 1.0 (only bit FRAC set), the result is exactly zero.
- R5: At the top of the range, for `mant_i` with all bits set (2 - 2^-FRAC), the result meets the R3 tolerance.
- R6: A `start_i` pulse arriving while a computation is in flight is ignored. The running result and its `done_o` timing are unchanged, and no extra `done_o` follows.
- R7: `ln_o` changes only in a cycle where `done_o` is high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a computation |
| mant_i | input | FRAC+1 | Mantissa, unsigned Q1.FRAC, sampled with `start_i` |
| done_o | output | 1 | One-cycle completion strobe |
| ln_o | output | FRAC | Natural logarithm, unsigned Q0.FRAC |

## Verification
The bench runs with FRAC=32, so each result is due NSTEP=9 rising edges after the edge that samples `start_i`. The driver changes inputs on falling edges and logs the cycle count at which it raised `start_i` with every expected item. The monitor samples on falling edges. When `done_o` is seen, it checks that the distance to that logged count is exactly ten edges, which is one edge to accept the start plus nine iteration edges. It then compares `ln_o` against a real-valued reference. The test for ignored starts waits a further full latency after completion, to show that no late strobe appears.

// File: rtl/hyp_ln_pkg.sv
// Shared constants and elaboration-time helpers for the hyperbolic log core.
// Assumes shifts start at 1 and that the standard hyperbolic repeat indices
// (4, 13, 40, ... each r -> 3r+1) are each used twice.
package hyp_ln_pkg;

    localparam int LANES = 4;

    // Shift amount used by micro-rotation number k (k counts from 0).
    function automatic int shift_at(input int k);
        int s;
        int rep;
        bit dup;
        s   = 1;
        rep = 4;
        dup = 1'b0;
        for (int t = 0; t < k; t++) begin
            if (s == rep && !dup) begin
                dup = 1'b1;
            end else begin
                if (s == rep) begin
                    rep = 3 * rep + 1;
                    dup = 1'b0;
                end
                s++;
            end
        end
        return s;
    endfunction

    // Number of repeated shifts whose value does not exceed lim.
    function automatic int rep_count(input int lim);
        int r;
        int n;
        r = 4;
        n = 0;
        while (r <= lim) begin
            n++;
            r = 3 * r + 1;
        end
        return n;
    endfunction

endpackage

// File: rtl/hyp_ln_angles.sv
// Constant tables for the iteration schedule: for each iteration cycle and
// lane, the shift amount and atanh(2^-shift) at FW fraction bits.
// Assumes step_i is below NSTEP while the core is busy; other indices read 0.
module hyp_ln_angles
    import hyp_ln_pkg::*;
#(
    parameter int FW    = 40,
    parameter int SHW   = 6,
    parameter int NSTEP = 9,
    parameter int CW    = 4
) (
    input  logic [CW-1:0]                  step_i,
    output logic [LANES-1:0][SHW-1:0]      sh_o,
    output logic [LANES-1:0][FW:0]         ang_o
);

    localparam int AW = FW + 1;

    // atanh(2^-s) scaled by 2^FW, summed from its odd power series.
    function automatic logic [AW-1:0] atanh_fx(input int s);
        logic [AW-1:0] acc;
        logic [AW-1:0] term;
        acc = '0;
        for (int j = 0; j < FW; j++) begin
            int p;
            p = s * (2 * j + 1);
            if (p <= FW) begin
                term = (AW'(1) << FW) >> p;
                acc  = acc + term / AW'(2 * j + 1);
            end
        end
        return acc;
    endfunction

    logic [SHW-1:0] sh_tab  [NSTEP][LANES];
    logic [AW-1:0]  ang_tab [NSTEP][LANES];

    for (genvar st = 0; st < NSTEP; st++) begin : g_step
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            localparam int            SH  = shift_at(st * LANES + ln);
            localparam logic [AW-1:0] ANG = atanh_fx(SH);
            assign sh_tab[st][ln]  = SHW'(SH);
            assign ang_tab[st][ln] = ANG;
        end
    end

    // Read the four lanes belonging to the current iteration cycle.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            if ({1'b0, step_i} < (CW + 1)'(NSTEP)) begin
                sh_o[l]  = sh_tab[step_i][l];
                ang_o[l] = ang_tab[step_i][l];
            end else begin
                sh_o[l]  = '0;
                ang_o[l] = '0;
            end
        end
    end

endmodule

// File: rtl/hyp_ln_quad.sv
// One iteration cycle: four one-sided hyperbolic micro-rotations resolved at
// once. A binary tree holds every apply/skip path; node n has skip child 2n
// and apply child 2n+1. The sign of each apply child's y picks the digit.
// Assumes y_i <= 0; the selected path keeps y non-positive.
module hyp_ln_quad
    import hyp_ln_pkg::*;
#(
    parameter int W   = 43,
    parameter int ZW  = 41,
    parameter int SHW = 6
) (
    input  logic signed [W-1:0]            x_i,
    input  logic signed [W-1:0]            y_i,
    input  logic [ZW-1:0]                  z_i,
    input  logic [LANES-1:0][SHW-1:0]      sh_i,
    input  logic [LANES-1:0][ZW-1:0]       ang_i,
    output logic signed [W-1:0]            x_o,
    output logic signed [W-1:0]            y_o,
    output logic [ZW-1:0]                  z_o
);

    localparam int NODES = 2 ** (LANES + 1);
    localparam int PW    = LANES + 1;

    logic signed [W-1:0] nx [NODES];
    logic signed [W-1:0] ny [NODES];

    assign nx[0] = '0;
    assign ny[0] = '0;
    assign nx[1] = x_i;
    assign ny[1] = y_i;

    for (genvar n = 1; n < NODES / 2; n++) begin : g_node
        localparam int LV = $clog2(n + 1) - 1;
        assign nx[2*n]   = nx[n];
        assign ny[2*n]   = ny[n];
        assign nx[2*n+1] = nx[n] + (ny[n] >>> sh_i[LV]);
        assign ny[2*n+1] = ny[n] + (nx[n] >>> sh_i[LV]);
    end

    // Walk the tree: apply a rotation whenever its result keeps y <= 0.
    always_comb begin
        logic [PW-1:0] p;
        logic [ZW-1:0] zacc;
        p    = PW'(1);
        zacc = z_i;
        for (int l = 0; l < LANES; l++) begin
            if (ny[{p[LANES-1:0], 1'b1}] <= 0) begin
                p    = {p[LANES-1:0], 1'b1};
                zacc = zacc + ang_i[l];
            end else begin
                p    = {p[LANES-1:0], 1'b0};
            end
        end
        x_o = nx[p];
        y_o = ny[p];
        z_o = zacc;
    end

endmodule

// File: rtl/hyp_ln_core.sv
// Natural logarithm of a Q1.FRAC mantissa in [1,2) by hyperbolic CORDIC
// vectoring, four digits per cycle. Result = 2*atanh((m-1)/(m+1)), rounded
// to Q0.FRAC. Assumes mant_i[FRAC] == 1; start_i is ignored while busy.
module hyp_ln_core
    import hyp_ln_pkg::*;
#(
    parameter int FRAC  = 112,
    parameter int GUARD = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [FRAC:0]   mant_i,
    output logic            done_o,
    output logic [FRAC-1:0] ln_o
);

    localparam int IF    = FRAC + GUARD;
    localparam int W     = IF + 3;
    localparam int ZW    = IF + 1;
    localparam int NITER = FRAC + 2 + rep_count(FRAC + 2);
    localparam int NSTEP = (NITER + LANES - 1) / LANES;
    localparam int CW    = $clog2(NSTEP);
    localparam int SHW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(NSTEP - 1);
    localparam logic [ZW-1:0] RND  = ZW'(1) << (GUARD - 2);
    localparam logic signed [W-1:0] ONE = W'(1) << IF;

    logic                         busy_q;
    logic [CW-1:0]                cnt_q;
    logic signed [W-1:0]          x_q, y_q, x_nx, y_nx, m_ext;
    logic [ZW-1:0]                z_q, z_nx;
    logic                         done_q;
    logic [FRAC-1:0]              res_q, res_d;
    logic [LANES-1:0][SHW-1:0]    sh;
    logic [LANES-1:0][ZW-1:0]     ang;

    assign m_ext = W'(mant_i) << GUARD;
    assign res_d = FRAC'((z_nx + RND) >> (GUARD - 1));

    hyp_ln_angles #(.FW(IF), .SHW(SHW), .NSTEP(NSTEP), .CW(CW)) u_angles (
        .step_i (cnt_q),
        .sh_o   (sh),
        .ang_o  (ang)
    );

    hyp_ln_quad #(.W(W), .ZW(ZW), .SHW(SHW)) u_quad (
        .x_i   (x_q),
        .y_i   (y_q),
        .z_i   (z_q),
        .sh_i  (sh),
        .ang_i (ang),
        .x_o   (x_nx),
        .y_o   (y_nx),
        .z_o   (z_nx)
    );

    // Load on an idle start, iterate while busy, publish on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                    x_q    <= m_ext + ONE;
                    y_q    <= ONE - m_ext;
                    z_q    <= '0;
                end
            end else begin
                x_q   <= x_nx;
                y_q   <= y_nx;
                z_q   <= z_nx;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= res_d;
                end
            end
        end
    end

    assign done_o = done_q;
    assign ln_o   = res_q;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(busy_q) && $past(cnt_q) == LAST));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(res_q));

    // R3
    y_nonpos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (y_q <= 0));

    // R3
    z_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> (z_q >= $past(z_q)));

endmodule

// File: tb/test_hyp_ln_core.sv
`timescale 1ns/1ps
module test_hyp_ln_core;

    localparam int  FRAC  = 32;
    localparam int  LAT   = 9;
    localparam real SCALE = 4294967296.0;

    typedef struct {
        real expv;
        int  stamp;
        int  tol;
        int  req;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start_i;
    logic [FRAC:0]   mant_i;
    logic            done_o;
    logic [FRAC-1:0] ln_o;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    int    n_done = 0;
    int    n_jobs = 0;
    logic  prev_done = 1'b0;
    logic [FRAC-1:0] last_res = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hyp_ln_core #(.FRAC(FRAC)) i_hyp_ln_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mant_i  (mant_i),
        .done_o  (done_o),
        .ln_o    (ln_o)
    );

    task automatic note(input bit ok, input int req, input string what,
                        input real act, input real expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual=%f expected=%f", req, what, act, expv);
        end
    endtask

    // Driver: raise start for one cycle and queue the expected outcome.
    task automatic push_job(input logic [FRAC:0] m, input int tol, input int req);
        item_t it;
        @(negedge clk);
        start_i = 1'b1;
        mant_i  = m;
        it.expv  = $ln(real'(m) / SCALE) * SCALE;
        it.stamp = cyc;
        it.tol   = tol;
        it.req   = req;
        q.push_back(it);
        n_jobs++;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_job(input logic [FRAC:0] m, input int tol, input int req);
        push_job(m, tol, req);
        repeat (LAT) @(negedge clk);
    endtask

    // Monitor: pop and compare at each completion strobe.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (done_o && prev_done)
                note(1'b0, 2, "done longer than one cycle", 1.0, 0.0);
            if (done_o) begin
                n_done++;
                if (q.size() == 0) begin
                    note(1'b0, 6, "unexpected done", 1.0, 0.0);
                end else begin
                    item_t it;
                    real   diff;
                    it = q.pop_front();
                    note((cyc - it.stamp) == LAT + 1, 2, "latency",
                         real'(cyc - it.stamp), real'(LAT + 1));
                    diff = real'(ln_o) - it.expv;
                    if (diff < 0.0) diff = -diff;
                    note(diff <= real'(it.tol), it.req, "ln value",
                         real'(ln_o), it.expv);
                end
                last_res = ln_o;
            end
            prev_done = done_o;
        end
    end

    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        rst_n   = 1'b0;
        start_i = 1'b0;
        mant_i  = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        note(done_o == 1'b0, 1, "done after reset", real'(done_o), 0.0);
        note(ln_o == '0, 1, "ln after reset", real'(ln_o), 0.0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: exact zero for m = 1
        run_job({1'b1, 32'h0000_0000}, 0, 4);
        // R3: small offset and mid-range values
        run_job({1'b1, 32'h0000_0001}, 3, 3);
        run_job({1'b1, 32'h8000_0000}, 3, 3);
        run_job({1'b1, 32'h4000_0000}, 3, 3);
        run_job({1'b1, 32'h6A09_E668}, 3, 3);
        run_job({1'b1, 32'hC000_0000}, 3, 3);
        // R5: top end of the range
        run_job({1'b1, 32'hFFFF_FFFF}, 3, 5);
        run_job({1'b1, 32'hFFF0_0000}, 3, 5);

        // R3: pseudo-random mantissas
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 16; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run_job({1'b1, lfsr}, 3, 3);
        end

        // R6: start pulses while busy carry other mantissas and are ignored
        push_job({1'b1, 32'h2000_0000}, 3, 6);
        repeat (2) @(negedge clk);
        start_i = 1'b1;
        mant_i  = {1'b1, 32'hF000_0000};
        @(negedge clk);
        mant_i  = {1'b1, 32'h0000_0000};
        @(negedge clk);
        start_i = 1'b0;
        repeat (LAT - 4) @(negedge clk);
        repeat (LAT + 3) @(negedge clk);
        note(n_done == n_jobs, 6, "completions vs accepted starts",
             real'(n_done), real'(n_jobs));

        // R7: result held while the next computation runs
        push_job({1'b1, 32'h9000_0000}, 3, 3);
        repeat (4) @(negedge clk);
        note(ln_o == last_res, 7, "ln held mid-run", real'(ln_o), real'(last_res));
        repeat (LAT - 4) @(negedge clk);
        repeat (3) @(negedge clk);
        note(ln_o == last_res, 7, "ln held after done", real'(ln_o), real'(last_res));

        note(q.size() == 0, 2, "outstanding results", real'(q.size()), 0.0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule